// File: doc/BRIEF.md
# Bus Access Policy Firewall

This block guards one slave peripheral on a simplified request/response bus. A master issues a request (direction, transfer size, address, write data) on a valid/ready channel; the firewall accepts it, reads one 32-bit rule word from an attached synchronous policy RAM, and compares the rule with the request. A legal request is forwarded unchanged to the slave, and the slave's response is returned to the master. An illegal request never reaches the slave. A blocked write is completed locally with a normal-looking response. A blocked read returns an error flag together with either zero or a fixed, parameterised error value.

The rule word is selected by a 4-bit requester-ID register. A separate strobe loads this register before each access, and its value is the RAM address, so each of the 16 requesters has its own rule. Only one transaction is in flight at a time. Both the request and response channels follow valid/ready rules. A source holds valid, and everything it presents, stable until the cycle in which ready is also high. The firewall lowers request ready from acceptance until its response handshake completes, and it keeps a response stable for as long as the master holds response ready low. A one-cycle attack flag carrying the requester ID marks every blocked transaction.

Top module: `bus_policy_firewall`

## Requirements
- R1: After reset, `m_req_ready` is 1. `m_rsp_valid`, `s_req_valid` and `attack_valid` are 0, and the ID register holds 0.
- R2: A cycle with `id_wr_en` high loads `id_wr_val` into the ID register. The next accepted request reads the rule word at RAM address equal to that ID.
- R3: On a request handshake the block pulses `pol_rd_en` for exactly one cycle and reads the rule in the following cycle. `m_req_ready` stays low from acceptance until the response handshake, so only one transaction is ever outstanding.
- R4: Rule bits [1:0] give the access right: 00 = none, 01 = write only, 10 = read only, 11 = read and write. A request whose direction is not granted is blocked.
- R5: Rule bits [3:2] give the widest allowed transfer, and `m_req_size` uses the same code (00 = 4, 01 = 8, 10 = 16, 11 = 32 bits). A request whose size code is greater than the rule's code is blocked, and an equal code is allowed.
- R6: An allowed request appears on the slave port with direction, size, address and write data unchanged. The slave's read data and error flag are passed back to the master unchanged.
- R7: A blocked write never raises `s_req_valid`. The firewall answers it itself with `m_rsp_err` = 0.
- R8: A blocked read never raises `s_req_valid`. It answers with `m_rsp_err` = 1, and its read data is the parameter ERR_VALUE when rule bit 4 (error mode) is 1, or zero when that bit is 0.
- R9: For every blocked transaction, `attack_valid` is high for exactly one cycle, the first cycle of the local response, and `attack_id` carries the requester ID. Allowed transactions never raise it.
- R10: While `m_rsp_valid` is high and `m_rsp_ready` is low, the response stays valid and its data and error flag stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_wr_en | input | 1 | Strobe that loads the requester-ID register |
| id_wr_val | input | 4 | New requester ID |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Firewall can accept a request |
| m_req_write | input | 1 | 1 = write, 0 = read |
| m_req_size | input | 2 | Transfer size code |
| m_req_addr | input | 16 | Request address |
| m_req_wdata | input | 32 | Write data |
| m_rsp_valid | output | 1 | Response valid toward the master |
| m_rsp_ready | input | 1 | Master accepts the response |
| m_rsp_rdata | output | 32 | Response read data |
| m_rsp_err | output | 1 | Response error flag |
| s_req_valid | output | 1 | Forwarded request valid |
| s_req_ready | input | 1 | Slave accepts the request |
| s_req_write | output | 1 | Forwarded direction |
| s_req_size | output | 2 | Forwarded size code |
| s_req_addr | output | 16 | Forwarded address |
| s_req_wdata | output | 32 | Forwarded write data |
| s_rsp_valid | input | 1 | Slave response valid |
| s_rsp_ready | output | 1 | Firewall accepts the slave response |
| s_rsp_rdata | input | 32 | Slave read data |
| s_rsp_err | input | 1 | Slave error flag |
| pol_rd_en | output | 1 | Policy RAM read enable |
| pol_addr | output | 4 | Policy RAM address (requester ID) |
| pol_rdata | input | 32 | Policy word, valid the cycle after `pol_rd_en` |
| attack_valid | output | 1 | One-cycle flag for a blocked transaction |
| attack_id | output | 4 | Requester ID of the blocked transaction |

## Verification
The hold and stability properties assume that the neighbours obey the channel rules. The master keeps its request fields constant while valid is waiting for ready. The slave keeps its read data and error flag constant while its response waits. The policy RAM answers exactly one cycle after a read enable. The bench's master and slave models change their outputs only at falling edges and only after a handshake has completed, and its RAM model is a registered array. The stimulus also loads the ID register only while the firewall is idle, so every rule fetch uses a settled ID.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_WO   = 2'b01,
    ACC_RO   = 2'b10,
    ACC_RW   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    WID_4  = 2'b00,
    WID_8  = 2'b01,
    WID_16 = 2'b10,
    WID_32 = 2'b11
  } width_e;

  // rule word bits [4:0]: err_mode at 4, width at [3:2], access at [1:0]
  typedef struct packed {
    logic   err_mode;
    width_e width;
    acc_e   acc;
  } rule_t;

  localparam int RULE_BITS = $bits(rule_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FWD,
    ST_WAIT,
    ST_LOCAL
  } fw_state_e;

  function automatic logic dir_granted(acc_e a, logic is_write);
    if (is_write) return (a == ACC_WO) || (a == ACC_RW);
    else          return (a == ACC_RO) || (a == ACC_RW);
  endfunction

endpackage

// File: rtl/fw_id_reg.sv
module fw_id_reg #(
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IDW-1:0] wr_val,
  output logic [IDW-1:0] id_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (wr_en) id_q <= wr_val;
  end

  // R2: the register takes the written ID
  a_r2_id_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> id_q == $past(wr_val));

endmodule

// File: rtl/fw_rule_check.sv
module fw_rule_check
  import fw_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic [PW-1:0] rule_word,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  output logic          allow,
  output logic          err_mode
);

  localparam int USED = RULE_BITS;

  rule_t rule;
  logic  dir_ok;
  logic  size_ok;

  generate
    if (PW >= USED) begin : g_fit
      assign rule = rule_t'(rule_word[USED-1:0]);
    end else begin : g_pad
      assign rule = rule_t'({{(USED-PW){1'b0}}, rule_word});
    end
  endgenerate

  always_comb begin
    dir_ok   = dir_granted(rule.acc, req_write);
    size_ok  = (req_size <= rule.width);
    allow    = dir_ok && size_ok;
    err_mode = rule.err_mode;
  end

  // R4: a rule with no access right never lets anything through
  always_comb begin
    if (rule.acc == ACC_NONE) begin
      a_r4_none_blocks: assert (!allow);
    end
  end

endmodule

// File: rtl/fw_ctrl.sv
module fw_ctrl
  import fw_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter int          IDW       = 4,
  parameter int          PW        = 32,
  parameter logic [DW-1:0] ERR_VALUE = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IDW-1:0] id_q,
  input  logic           m_req_valid,
  output logic           m_req_ready,
  input  logic           m_req_write,
  input  logic [1:0]     m_req_size,
  input  logic [AW-1:0]  m_req_addr,
  input  logic [DW-1:0]  m_req_wdata,
  output logic           m_rsp_valid,
  input  logic           m_rsp_ready,
  output logic [DW-1:0]  m_rsp_rdata,
  output logic           m_rsp_err,
  output logic           s_req_valid,
  input  logic           s_req_ready,
  output logic           s_req_write,
  output logic [1:0]     s_req_size,
  output logic [AW-1:0]  s_req_addr,
  output logic [DW-1:0]  s_req_wdata,
  input  logic           s_rsp_valid,
  output logic           s_rsp_ready,
  input  logic [DW-1:0]  s_rsp_rdata,
  input  logic           s_rsp_err,
  output logic           pol_rd_en,
  output logic [IDW-1:0] pol_addr,
  input  logic [PW-1:0]  pol_rdata,
  output logic           attack_valid,
  output logic [IDW-1:0] attack_id
);

  fw_state_e      state;
  logic           req_write;
  logic [1:0]     req_size;
  logic [AW-1:0]  req_addr;
  logic [DW-1:0]  req_wdata;
  logic [IDW-1:0] req_id;
  logic [DW-1:0]  loc_rdata;
  logic           loc_err;
  logic           attack_q;
  logic           allow;
  logic           err_mode;
  logic           accept;

  fw_rule_check #(.PW(PW)) u_check (
    .rule_word (pol_rdata),
    .req_write (req_write),
    .req_size  (req_size),
    .allow     (allow),
    .err_mode  (err_mode)
  );

  assign m_req_ready = (state == ST_IDLE);
  assign accept      = m_req_valid && m_req_ready;
  assign pol_rd_en   = accept;
  assign pol_addr    = id_q;

  assign s_req_valid = (state == ST_FWD);
  assign s_req_write = req_write;
  assign s_req_size  = req_size;
  assign s_req_addr  = req_addr;
  assign s_req_wdata = req_wdata;

  always_comb begin
    m_rsp_valid = 1'b0;
    m_rsp_rdata = '0;
    m_rsp_err   = 1'b0;
    s_rsp_ready = 1'b0;
    case (state)
      ST_WAIT: begin
        m_rsp_valid = s_rsp_valid;
        m_rsp_rdata = s_rsp_rdata;
        m_rsp_err   = s_rsp_err;
        s_rsp_ready = m_rsp_ready;
      end
      ST_LOCAL: begin
        m_rsp_valid = 1'b1;
        m_rsp_rdata = loc_rdata;
        m_rsp_err   = loc_err;
      end
      default: ;
    endcase
  end

  assign attack_valid = attack_q;
  assign attack_id    = attack_q ? req_id : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_write <= 1'b0;
      req_size  <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_id    <= '0;
      loc_rdata <= '0;
      loc_err   <= 1'b0;
      attack_q  <= 1'b0;
    end else begin
      attack_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            req_write <= m_req_write;
            req_size  <= m_req_size;
            req_addr  <= m_req_addr;
            req_wdata <= m_req_wdata;
            req_id    <= id_q;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (allow) begin
            state <= ST_FWD;
          end else begin
            state     <= ST_LOCAL;
            loc_err   <= !req_write;
            loc_rdata <= (!req_write && err_mode) ? ERR_VALUE : '0;
            attack_q  <= 1'b1;
          end
        end
        ST_FWD:   if (s_req_ready) state <= ST_WAIT;
        ST_WAIT:  if (s_rsp_valid && m_rsp_ready) state <= ST_IDLE;
        ST_LOCAL: if (m_rsp_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R3: one rule fetch per accepted request, and no new request meanwhile
  a_r3_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    pol_rd_en |=> !pol_rd_en && !m_req_ready);

  // R9: the attack flag lasts one cycle
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    attack_valid |=> !attack_valid);

  // R9: the flag marks the first cycle of a local response
  a_r9_with_local_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    attack_valid |-> m_rsp_valid && !s_req_valid && !s_rsp_ready);

  // R7: after a block decision nothing is forwarded to the slave
  a_r7_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    attack_valid |=> !s_req_valid);

  // R6: a forwarded request holds until the slave accepts it
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_valid && !s_req_ready |=> s_req_valid && $stable(s_req_addr) && $stable(s_req_wdata));

  // R10: a stalled response stays put
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_valid && !m_rsp_ready |=> m_rsp_valid && $stable(m_rsp_rdata) && $stable(m_rsp_err));

endmodule

// File: rtl/bus_policy_firewall.sv
module bus_policy_firewall #(
  parameter int            AW        = 16,
  parameter int            DW        = 32,
  parameter int            IDW       = 4,
  parameter int            PW        = 32,
  parameter logic [DW-1:0] ERR_VALUE = 32'hDEAD_BEEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           id_wr_en,
  input  logic [IDW-1:0] id_wr_val,
  input  logic           m_req_valid,
  output logic           m_req_ready,
  input  logic           m_req_write,
  input  logic [1:0]     m_req_size,
  input  logic [AW-1:0]  m_req_addr,
  input  logic [DW-1:0]  m_req_wdata,
  output logic           m_rsp_valid,
  input  logic           m_rsp_ready,
  output logic [DW-1:0]  m_rsp_rdata,
  output logic           m_rsp_err,
  output logic           s_req_valid,
  input  logic           s_req_ready,
  output logic           s_req_write,
  output logic [1:0]     s_req_size,
  output logic [AW-1:0]  s_req_addr,
  output logic [DW-1:0]  s_req_wdata,
  input  logic           s_rsp_valid,
  output logic           s_rsp_ready,
  input  logic [DW-1:0]  s_rsp_rdata,
  input  logic           s_rsp_err,
  output logic           pol_rd_en,
  output logic [IDW-1:0] pol_addr,
  input  logic [PW-1:0]  pol_rdata,
  output logic           attack_valid,
  output logic [IDW-1:0] attack_id
);

  logic [IDW-1:0] id_q;

  fw_id_reg #(.IDW(IDW)) u_id (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (id_wr_en),
    .wr_val (id_wr_val),
    .id_q   (id_q)
  );

  fw_ctrl #(
    .AW(AW), .DW(DW), .IDW(IDW), .PW(PW), .ERR_VALUE(ERR_VALUE)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_q         (id_q),
    .m_req_valid  (m_req_valid),
    .m_req_ready  (m_req_ready),
    .m_req_write  (m_req_write),
    .m_req_size   (m_req_size),
    .m_req_addr   (m_req_addr),
    .m_req_wdata  (m_req_wdata),
    .m_rsp_valid  (m_rsp_valid),
    .m_rsp_ready  (m_rsp_ready),
    .m_rsp_rdata  (m_rsp_rdata),
    .m_rsp_err    (m_rsp_err),
    .s_req_valid  (s_req_valid),
    .s_req_ready  (s_req_ready),
    .s_req_write  (s_req_write),
    .s_req_size   (s_req_size),
    .s_req_addr   (s_req_addr),
    .s_req_wdata  (s_req_wdata),
    .s_rsp_valid  (s_rsp_valid),
    .s_rsp_ready  (s_rsp_ready),
    .s_rsp_rdata  (s_rsp_rdata),
    .s_rsp_err    (s_rsp_err),
    .pol_rd_en    (pol_rd_en),
    .pol_addr     (pol_addr),
    .pol_rdata    (pol_rdata),
    .attack_valid (attack_valid),
    .attack_id    (attack_id)
  );

  // R1: quiet outputs while idle right after reset
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> m_req_ready && !m_rsp_valid && !s_req_valid && !attack_valid);

endmodule

// File: tb/bus_policy_firewall_test.sv
`timescale 1ns/1ps
module bus_policy_firewall_test;

  localparam logic [31:0] ERRV = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_wr_en = 1'b0;
  logic [3:0]  id_wr_val = '0;
  logic        m_req_valid = 1'b0, m_req_ready, m_req_write = 1'b0;
  logic [1:0]  m_req_size = '0;
  logic [15:0] m_req_addr = '0;
  logic [31:0] m_req_wdata = '0;
  logic        m_rsp_valid, m_rsp_ready = 1'b0, m_rsp_err;
  logic [31:0] m_rsp_rdata;
  logic        s_req_valid, s_req_ready = 1'b0, s_req_write;
  logic [1:0]  s_req_size;
  logic [15:0] s_req_addr;
  logic [31:0] s_req_wdata;
  logic        s_rsp_valid = 1'b0, s_rsp_ready, s_rsp_err = 1'b0;
  logic [31:0] s_rsp_rdata = '0;
  logic        pol_rd_en;
  logic [3:0]  pol_addr;
  logic [31:0] pol_rdata = '0;
  logic        attack_valid;
  logic [3:0]  attack_id;

  always #2 clk = ~clk;

  bus_policy_firewall #(.ERR_VALUE(ERRV)) uut (.*);

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // policy RAM model, one cycle read latency
  logic [31:0] pol_mem [16];
  always @(posedge clk) if (pol_rd_en) pol_rdata <= pol_mem[pol_addr];

  // slave model
  int          fwd_cnt = 0;
  logic        sl_write;
  logic [1:0]  sl_size;
  logic [15:0] sl_addr;
  logic [31:0] sl_wdata;
  initial begin
    forever begin
      @(negedge clk);
      if (s_req_valid) begin
        sl_write = s_req_write; sl_size = s_req_size;
        sl_addr = s_req_addr;   sl_wdata = s_req_wdata;
        s_req_ready = 1'b1;
        @(posedge clk);
        fwd_cnt++;
        @(negedge clk);
        s_req_ready = 1'b0;
        @(negedge clk);
        s_rsp_valid = 1'b1;
        s_rsp_rdata = {16'hC0DE, sl_addr};
        s_rsp_err   = sl_addr[15];
        while (!s_rsp_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        s_rsp_valid = 1'b0;
      end
    end
  end

  // per-clock comparison against the expected verdict of the live transaction
  bit         txn_active = 0;
  bit         exp_allow  = 0;
  logic [3:0] exp_id     = '0;
  int         atk_cnt    = 0;
  always @(negedge clk) begin
    if (rst_n && txn_active) begin
      if (s_req_valid) check(exp_allow, "R7/R8 blocked request reached slave", 32'(s_req_valid), 32'(exp_allow));
      if (attack_valid) begin
        atk_cnt++;
        check(!exp_allow, "R9 attack flag on allowed transaction", 32'(attack_valid), 0);
        check(attack_id == exp_id, "R9 attack_id", 32'(attack_id), 32'(exp_id));
      end
    end
  end

  function automatic bit ref_allow(logic [31:0] rule, bit w, logic [1:0] sz);
    bit dir_ok = w ? rule[0] : rule[1];
    return dir_ok && (sz <= rule[3:2]);
  endfunction

  task automatic do_txn(input logic [3:0] id, input bit w, input logic [15:0] a,
                        input logic [1:0] sz, input logic [31:0] wd, input int hold);
    int          fwd0, atk0;
    logic [31:0] exp_data, first_data;
    logic        exp_err, first_err;
    @(negedge clk);
    id_wr_en = 1'b1; id_wr_val = id;
    @(negedge clk);
    id_wr_en = 1'b0;
    exp_allow = ref_allow(pol_mem[id], w, sz);
    exp_id = id;
    fwd0 = fwd_cnt; atk0 = atk_cnt;
    txn_active = 1;
    m_req_valid = 1'b1; m_req_write = w; m_req_size = sz; m_req_addr = a; m_req_wdata = wd;
    while (!m_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    m_req_valid = 1'b0;
    check(!m_req_ready, "R3 ready low while rule is fetched", 32'(m_req_ready), 0);
    while (!m_rsp_valid) begin
      check(!m_req_ready, "R3 ready low while outstanding", 32'(m_req_ready), 0);
      @(negedge clk);
    end
    first_data = m_rsp_rdata; first_err = m_rsp_err;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(m_rsp_valid && m_rsp_rdata == first_data && m_rsp_err == first_err,
            "R10 response held under back-pressure", m_rsp_rdata, first_data);
    end
    m_rsp_ready = 1'b1;
    if (exp_allow) begin
      exp_data = w ? m_rsp_rdata : {16'hC0DE, a};
      exp_err  = a[15];
    end else begin
      exp_data = (!w && pol_mem[id][4]) ? ERRV : 32'h0;
      exp_err  = !w;
    end
    if (!w) check(m_rsp_rdata == exp_data, exp_allow ? "R6 read data" : "R8 blocked read data",
                  m_rsp_rdata, exp_data);
    check(m_rsp_err == exp_err, exp_allow ? "R6 error flag" : (w ? "R7 write err" : "R8 read err"),
          32'(m_rsp_err), 32'(exp_err));
    @(posedge clk);
    @(negedge clk);
    m_rsp_ready = 1'b0;
    txn_active = 0;
    check(fwd_cnt - fwd0 == (exp_allow ? 1 : 0), "R4/R5 forward decision",
          32'(fwd_cnt - fwd0), 32'(exp_allow));
    check(atk_cnt - atk0 == (exp_allow ? 0 : 1), "R9 attack pulse count",
          32'(atk_cnt - atk0), 32'(!exp_allow));
    if (exp_allow)
      check(sl_write == w && sl_size == sz && sl_addr == a && (!w || sl_wdata == wd),
            "R6 forwarded fields", {sl_addr, 14'h0, sl_size}, {a, 14'h0, sz});
    check(m_req_ready, "R3 ready back after response", 32'(m_req_ready), 1);
  endtask

  initial begin
    repeat (8000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) pol_mem[i] = 32'h0;
    pol_mem[0]  = 32'h0000_000F;  // rw, 32
    pol_mem[1]  = 32'h0000_0005;  // write only, 8
    pol_mem[2]  = 32'h0000_001E;  // read only, 32, error mode
    pol_mem[3]  = 32'h0000_000C;  // none, 32, no error mode
    pol_mem[4]  = 32'h0000_0002;  // read only, 4
    pol_mem[5]  = 32'h0000_001B;  // rw, 16, error mode
    pol_mem[15] = 32'hFFFF_FFE0;  // none, 4 (upper bits ignored)
    repeat (3) @(negedge clk);
    // R1 reset state
    check(m_req_ready == 1'b1, "R1 ready after reset", 32'(m_req_ready), 1);
    check(!m_rsp_valid && !s_req_valid && !attack_valid, "R1 quiet outputs",
          {29'h0, m_rsp_valid, s_req_valid, attack_valid}, 0);
    check(pol_addr == 4'h0, "R1 ID register is zero", 32'(pol_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_req_ready && !m_rsp_valid && !attack_valid, "R1 idle after release", 32'(m_req_ready), 1);

    do_txn(4'd0, 1'b1, 16'h0010, 2'b11, 32'h1234_5678, 0); // R6 write allowed
    do_txn(4'd0, 1'b0, 16'h0020, 2'b10, 32'h0, 0);         // R6 read allowed
    do_txn(4'd0, 1'b0, 16'h8024, 2'b00, 32'h0, 0);         // R6 slave error passes
    do_txn(4'd1, 1'b1, 16'h0030, 2'b01, 32'hCAFE_0001, 0); // R5 equal size allowed
    do_txn(4'd1, 1'b1, 16'h0034, 2'b10, 32'hCAFE_0002, 0); // R5 R7 too wide
    do_txn(4'd1, 1'b0, 16'h0038, 2'b00, 32'h0, 0);         // R4 R8 read on write only
    do_txn(4'd2, 1'b0, 16'h0040, 2'b11, 32'h0, 0);         // R4 read only ok
    do_txn(4'd2, 1'b1, 16'h0044, 2'b00, 32'hBAD0_0000, 0); // R4 R7 write on read only
    do_txn(4'd3, 1'b0, 16'h0050, 2'b00, 32'h0, 0);         // R4 R8 no access, zero data
    do_txn(4'd3, 1'b1, 16'h0054, 2'b00, 32'h1, 0);         // R4 R7 no access write
    do_txn(4'd5, 1'b0, 16'h0060, 2'b11, 32'h0, 0);         // R5 R8 error value
    do_txn(4'd5, 1'b1, 16'h0064, 2'b10, 32'h55AA_55AA, 0); // R5 16 ok
    do_txn(4'd4, 1'b0, 16'h0070, 2'b00, 32'h0, 0);         // R5 narrowest
    do_txn(4'd4, 1'b0, 16'h0074, 2'b01, 32'h0, 0);         // R5 narrowest exceeded
    do_txn(4'd2, 1'b0, 16'h0080, 2'b11, 32'h0, 3);         // R10 forwarded, stalled
    do_txn(4'd5, 1'b0, 16'h0084, 2'b11, 32'h0, 4);         // R10 R8 local, stalled
    do_txn(4'd15, 1'b0, 16'h0090, 2'b00, 32'h0, 0);        // R2 highest ID
    do_txn(4'd0, 1'b0, 16'h0094, 2'b00, 32'h0, 0);         // R2 ID switched back

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule